// File: doc/BRIEF.md
# Parallel NOR Erase Sequencer with Suspend and Resume

This block drives the command side of a byte-wide parallel NOR flash to erase either one sector or the whole array. A request latches the target, issues the six-write unlock-and-erase command train, and waits a programmable settle time before it starts polling. Polling reads the status word twice in a row. When both reads agree the device is idle and the erase is complete. If the reads never agree, the block gives up, sends the device reset command and reports an error.

An erase in progress can be paused so that another agent can read the array. The pause command goes to the stored in-progress address, and the block waits until the device reports idle before it releases the bus. A later resume request restarts the erase and also restarts the erase timeout from zero. While paused, the block leaves the flash bus idle and holds `busy` low.

Top module: `nor_erase_sequencer`

## Requirements
- R1: A sector request accepted while idle produces exactly six bus writes, one per cycle and back to back, as (data@address): AA@UNLOCK_A, 55@UNLOCK_B, 80@UNLOCK_A, AA@UNLOCK_A, 55@UNLOCK_B, 30@sector address. The sector address is the value on `req_addr` in the accepting cycle, and it is kept as the in-progress address.
- R2: A chip request uses the same first five writes and ends with 10@UNLOCK_A. UNLOCK_A then becomes the in-progress address, which all later pause, resume and reset writes use.
- R3: After the last command write the block waits max(floor(typ_erase/2),1) cycles with no bus traffic. The first status read therefore comes that many cycles plus one after the last write.
- R4: Polling reads the status word in pairs. When the two reads of a pair are equal, `done` pulses for exactly one cycle and `busy` goes low.
- R5: If polling continues without a matching pair for 20*timeout_base reads (rounded up to an even count), the block writes F0 to the in-progress address, pulses `error` for one cycle and returns to idle without pulsing `done`.
- R6: A pause request while the erase is settling or polling writes B0 to the in-progress address, then reads in pairs. On a matching pair it raises `suspended` and drops `busy`.
- R7: If the pause wait reaches timeout_base reads (rounded up to even) without a match, the block pulses `error`, writes 30 to the in-progress address, and resumes polling with `busy` high and `suspended` low.
- R8: A resume request while paused writes 30 to the in-progress address and drops `suspended`. Polling then resumes at once, with the full erase timeout counted again from zero.
- R9: Pause requests are ignored unless an erase is settling or polling. Resume requests are ignored unless the block is paused. Erase requests are ignored unless the block is idle.
- R10: If sector and chip requests arrive in the same idle cycle, the sector erase wins.
- R11: The write and read strobes are never high together, and both stay low while the block is idle or paused.
- R12: After reset, `busy`, `suspended`, `done`, `error` and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_sector_erase | input | 1 | Start a sector erase at `req_addr` |
| req_chip_erase | input | 1 | Start a whole-array erase |
| req_suspend | input | 1 | Pause the erase in progress |
| req_resume | input | 1 | Continue a paused erase |
| req_addr | input | AW | Sector address for a sector erase |
| typ_erase | input | TW | Typical erase time in cycles; half of it is waited before polling |
| timeout_base | input | TW | Timeout unit; the erase limit is 20 units and the pause limit is 1 unit |
| fl_we | output | 1 | Flash bus write strobe |
| fl_re | output | 1 | Flash bus read strobe |
| fl_addr | output | AW | Flash bus address |
| fl_wdata | output | DW | Flash bus write data |
| fl_rdata | input | DW | Flash read data, sampled in the cycle `fl_re` is high |
| busy | output | 1 | An erase command, wait or poll is under way |
| suspended | output | 1 | Erase paused; the array may be read by others |
| done | output | 1 | One-cycle pulse when an erase completes |
| error | output | 1 | One-cycle pulse on an erase or pause timeout |

## Verification
The bench checks the read counts at which each timeout fires. A counter that compares against the wrong bound, or that misses one increment, is off by one or two reads. It also checks that a resume restarts the erase timeout: a design that keeps the old count aborts well before 20 units of reads after the resume write. It pauses during the settle window, where a design that only accepts pauses while polling would miss the request entirely. Finally, it sends pause and resume requests in the wrong states, where a design that does not filter them writes a stray command to the flash.

// File: rtl/nor_erase_sequencer.sv
module nor_erase_sequencer #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int TW = 12,
  parameter int unsigned UNLOCK_A = 'h555,
  parameter int unsigned UNLOCK_B = 'h2AA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_sector_erase,
  input  logic          req_chip_erase,
  input  logic          req_suspend,
  input  logic          req_resume,
  input  logic [AW-1:0] req_addr,
  input  logic [TW-1:0] typ_erase,
  input  logic [TW-1:0] timeout_base,
  output logic          fl_we,
  output logic          fl_re,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  input  logic [DW-1:0] fl_rdata,
  output logic          busy,
  output logic          suspended,
  output logic          done,
  output logic          error
);
  localparam int CW = TW + 5;
  localparam logic [AW-1:0] ADDR_A = AW'(UNLOCK_A);
  localparam logic [AW-1:0] ADDR_B = AW'(UNLOCK_B);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_SETTLE, S_POLL_A, S_POLL_B,
    S_SUSP_CMD, S_SUSP_A, S_SUSP_B, S_HELD, S_RESUME, S_ABORT
  } state_t;

  state_t        state;
  logic [2:0]    step;
  logic [AW-1:0] blk_addr;
  logic          chip_mode;
  logic [DW-1:0] first_rd;
  logic [CW-1:0] cnt;
  logic          done_q, error_q;

  wire [CW-1:0] cnt_next    = cnt + CW'(1);
  wire [CW-1:0] settle_len  = CW'(typ_erase >> 1);
  wire [CW-1:0] erase_limit = CW'(timeout_base) * CW'(20);
  wire [CW-1:0] susp_limit  = CW'(timeout_base);
  wire          pair_match  = (fl_rdata == first_rd);

  assign busy      = (state != S_IDLE) && (state != S_HELD);
  assign suspended = (state == S_HELD);
  assign done      = done_q;
  assign error     = error_q;
  assign fl_re     = (state == S_POLL_A) || (state == S_POLL_B) ||
                     (state == S_SUSP_A) || (state == S_SUSP_B);

  always_comb begin
    fl_we    = 1'b0;
    fl_addr  = blk_addr;
    fl_wdata = '0;
    case (state)
      S_CMD: begin
        fl_we = 1'b1;
        case (step)
          3'd0:    begin fl_addr = ADDR_A; fl_wdata = DW'(8'hAA); end
          3'd1:    begin fl_addr = ADDR_B; fl_wdata = DW'(8'h55); end
          3'd2:    begin fl_addr = ADDR_A; fl_wdata = DW'(8'h80); end
          3'd3:    begin fl_addr = ADDR_A; fl_wdata = DW'(8'hAA); end
          3'd4:    begin fl_addr = ADDR_B; fl_wdata = DW'(8'h55); end
          default: fl_wdata = chip_mode ? DW'(8'h10) : DW'(8'h30);
        endcase
      end
      S_SUSP_CMD: begin fl_we = 1'b1; fl_wdata = DW'(8'hB0); end
      S_RESUME:   begin fl_we = 1'b1; fl_wdata = DW'(8'h30); end
      S_ABORT:    begin fl_we = 1'b1; fl_wdata = DW'(8'hF0); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      step      <= '0;
      blk_addr  <= '0;
      chip_mode <= 1'b0;
      first_rd  <= '0;
      cnt       <= '0;
      done_q    <= 1'b0;
      error_q   <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      error_q <= 1'b0;
      case (state)
        S_IDLE: begin
          step <= '0;
          if (req_sector_erase) begin
            blk_addr  <= req_addr;
            chip_mode <= 1'b0;
            state     <= S_CMD;
          end else if (req_chip_erase) begin
            blk_addr  <= ADDR_A;
            chip_mode <= 1'b1;
            state     <= S_CMD;
          end
        end
        S_CMD: begin
          if (step == 3'd5) begin
            cnt   <= '0;
            state <= S_SETTLE;
          end else begin
            step <= step + 3'd1;
          end
        end
        S_SETTLE: begin
          if (req_suspend) state <= S_SUSP_CMD;
          else if (cnt_next >= settle_len) begin
            cnt   <= '0;
            state <= S_POLL_A;
          end else cnt <= cnt_next;
        end
        S_POLL_A: begin
          if (req_suspend) state <= S_SUSP_CMD;
          else begin
            first_rd <= fl_rdata;
            cnt      <= cnt_next;
            state    <= S_POLL_B;
          end
        end
        S_POLL_B: begin
          if (pair_match) begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else if (cnt_next >= erase_limit) state <= S_ABORT;
          else if (req_suspend) state <= S_SUSP_CMD;
          else begin
            cnt   <= cnt_next;
            state <= S_POLL_A;
          end
        end
        S_SUSP_CMD: begin
          cnt   <= '0;
          state <= S_SUSP_A;
        end
        S_SUSP_A: begin
          first_rd <= fl_rdata;
          cnt      <= cnt_next;
          state    <= S_SUSP_B;
        end
        S_SUSP_B: begin
          if (pair_match) state <= S_HELD;
          else if (cnt_next >= susp_limit) begin
            error_q <= 1'b1;
            state   <= S_RESUME;
          end else begin
            cnt   <= cnt_next;
            state <= S_SUSP_A;
          end
        end
        S_HELD: if (req_resume) state <= S_RESUME;
        S_RESUME: begin
          cnt   <= '0;
          state <= S_POLL_A;
        end
        S_ABORT: begin
          error_q <= 1'b1;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nor_erase_sequencer_chk.sv
module nor_erase_sequencer_chk #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int TW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_sector_erase,
  input logic          req_chip_erase,
  input logic          req_suspend,
  input logic          req_resume,
  input logic [AW-1:0] req_addr,
  input logic [TW-1:0] typ_erase,
  input logic [TW-1:0] timeout_base,
  input logic          fl_we,
  input logic          fl_re,
  input logic [AW-1:0] fl_addr,
  input logic [DW-1:0] fl_wdata,
  input logic [DW-1:0] fl_rdata,
  input logic          busy,
  input logic          suspended,
  input logic          done,
  input logic          error
);
  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));
  assert_quiet_when_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> (!fl_we && !fl_re));
  assert_busy_held_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && suspended));
  assert_held_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> $past(fl_re));
  assert_resume_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(suspended) |-> (fl_we && fl_wdata == DW'(8'h30)));
  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !error));
  assert_idle_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !suspended && !req_sector_erase && !req_chip_erase) |=> !busy);
endmodule

bind nor_erase_sequencer nor_erase_sequencer_chk #(.AW(AW), .DW(DW), .TW(TW)) u_chk (.*);

// File: tb/nor_erase_sequencer_bench.sv
module nor_erase_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_sector_erase = 0, req_chip_erase = 0, req_suspend = 0, req_resume = 0;
  logic [15:0] req_addr = '0;
  logic [11:0] typ_erase = 12'd4, timeout_base = 12'd5;
  logic        fl_we, fl_re, busy, suspended, done, error;
  logic [15:0] fl_addr;
  logic [7:0]  fl_wdata, fl_rdata;

  always #2 clk = ~clk;

  nor_erase_sequencer u_nor_erase_sequencer (
    .clk(clk), .rst_n(rst_n), .req_sector_erase(req_sector_erase),
    .req_chip_erase(req_chip_erase), .req_suspend(req_suspend), .req_resume(req_resume),
    .req_addr(req_addr), .typ_erase(typ_erase), .timeout_base(timeout_base),
    .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_rdata(fl_rdata), .busy(busy), .suspended(suspended), .done(done), .error(error));

  // flash status model: busy for rem reads (negative = forever), toggling bit while busy
  int erase_reads = 0, susp_reads = 0;
  int rem = 0;
  logic tog = 1'b0;
  assign fl_rdata = (rem != 0) ? {1'b0, tog, 6'h15} : 8'hFF;
  always @(posedge clk) begin
    if (!rst_n) begin rem <= 0; tog <= 1'b0; end
    else begin
      if (fl_we) begin
        if (fl_wdata == 8'h30 || fl_wdata == 8'h10) rem <= erase_reads;
        else if (fl_wdata == 8'hB0) rem <= susp_reads;
        else if (fl_wdata == 8'hF0) rem <= 0;
      end
      if (fl_re) begin
        tog <= ~tog;
        if (rem > 0) rem <= rem - 1;
      end
    end
  end

  // bus monitor
  logic [15:0] wa [0:1023];
  logic [7:0]  wd [0:1023];
  int wr [0:1023];
  int wc [0:1023];
  int nw = 0, reads_since = 0, total_reads = 0, first_re_cyc = 0;
  int done_n = 0, err_n = 0, reads_at_done = 0, cyc = 0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (fl_we) begin
        wa[nw] = fl_addr; wd[nw] = fl_wdata; wr[nw] = reads_since; wc[nw] = cyc;
        nw = nw + 1; reads_since = 0;
      end
      if (fl_re) begin
        if (reads_since == 0) first_re_cyc = cyc;
        reads_since = reads_since + 1; total_reads = total_reads + 1;
      end
      if (done) begin done_n = done_n + 1; reads_at_done = reads_since; end
      if (error) err_n = err_n + 1;
    end
    cyc = cyc + 1;
  end

  int checks = 0, failures = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: req_sector_erase = 1;
      1: req_chip_erase = 1;
      2: req_suspend = 1;
      default: req_resume = 1;
    endcase
    @(negedge clk);
    req_sector_erase = 0; req_chip_erase = 0; req_suspend = 0; req_resume = 0;
  endtask

  task automatic wait_end(input int d0, input int e0);
    while (done_n == d0 && err_n == e0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_writes(input int n);
    while (nw < n) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic bit seq_ok(input int b, input logic [15:0] last_a, input logic [7:0] last_d);
    return wa[b] == 16'h555 && wd[b] == 8'hAA && wa[b+1] == 16'h2AA && wd[b+1] == 8'h55 &&
           wa[b+2] == 16'h555 && wd[b+2] == 8'h80 && wa[b+3] == 16'h555 && wd[b+3] == 8'hAA &&
           wa[b+4] == 16'h2AA && wd[b+4] == 8'h55 && wa[b+5] == last_a && wd[b+5] == last_d &&
           wc[b+5] == wc[b] + 5;
  endfunction

  initial begin
    logic [15:0] addrs [4];
    addrs[0] = 16'h0000; addrs[1] = 16'h1234; addrs[2] = 16'hFFFF; addrs[3] = 16'h8000;
    repeat (3) @(negedge clk);
    chk(!busy && !suspended && !done && !error && !fl_we && !fl_re, "R12", busy, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 / R4: sector erase sweep over addresses and ready latencies
    for (int i = 0; i < 4; i++) begin
      for (int r = 0; r < 4; r++) begin
        int b, d0, e0;
        b = nw; d0 = done_n; e0 = err_n;
        erase_reads = r; timeout_base = 12'd5; typ_erase = 12'd4;
        req_addr = addrs[i];
        pulse(0);
        wait_end(d0, e0);
        chk(nw == b + 6 && seq_ok(b, addrs[i], 8'h30), "R1 sequence", wd[b+5], 8'h30);
        chk(done_n == d0 + 1 && err_n == e0, "R4 done pulse", done_n - d0, 1);
        chk(reads_at_done == r + 2 + (r % 2), "R4 read pairs", reads_at_done, r + 2 + (r % 2));
        chk(!busy && !suspended, "R4 idle after done", busy, 0);
      end
    end

    // R3: settle window sweep
    for (int t = 0; t < 8; t++) begin
      int b, d0, e0, exp_gap;
      b = nw; d0 = done_n; e0 = err_n;
      erase_reads = 0; typ_erase = 12'(t); req_addr = 16'h0040;
      pulse(0);
      wait_end(d0, e0);
      exp_gap = ((t / 2) > 1 ? (t / 2) : 1) + 1;
      chk(first_re_cyc - wc[b+5] == exp_gap, "R3 settle", first_re_cyc - wc[b+5], exp_gap);
    end

    // R5: erase timeout for several bases
    for (int tb = 1; tb < 4; tb++) begin
      int b, d0, e0;
      b = nw; d0 = done_n; e0 = err_n;
      erase_reads = -1; typ_erase = 12'd2; timeout_base = 12'(tb); req_addr = 16'h0777;
      pulse(0);
      wait_end(d0, e0);
      chk(nw == b + 7 && wd[b+6] == 8'hF0 && wa[b+6] == 16'h0777, "R5 reset write", wd[b+6], 8'hF0);
      chk(wr[b+6] == 20 * tb, "R5 read count", wr[b+6], 20 * tb);
      chk(err_n == e0 + 1 && done_n == d0 && !busy, "R5 error pulse", err_n - e0, 1);
    end

    // R2: chip erase, pause and resume target UNLOCK_A
    begin
      int b, e0;
      b = nw; e0 = err_n;
      erase_reads = -1; susp_reads = 0; timeout_base = 12'd2; req_addr = 16'h1111;
      pulse(1);
      wait_writes(b + 6);
      chk(seq_ok(b, 16'h0555, 8'h10), "R2 sequence", wd[b+5], 8'h10);
      repeat (6) @(negedge clk);
      pulse(2);
      while (!suspended) @(negedge clk);
      chk(wd[b+6] == 8'hB0 && wa[b+6] == 16'h0555, "R2 pause address", wa[b+6], 16'h555);
      pulse(3);
      wait_writes(b + 8);
      chk(wd[b+7] == 8'h30 && wa[b+7] == 16'h0555, "R2 resume address", wa[b+7], 16'h555);
      wait_end(done_n, e0);
      chk(wd[b+8] == 8'hF0 && wa[b+8] == 16'h0555, "R2 reset address", wa[b+8], 16'h555);
    end

    // R6 / R8 / R9 / R11: pause during polling, restart of timeout
    begin
      int b, w0, r0, e0;
      b = nw; e0 = err_n;
      erase_reads = -1; susp_reads = 0; timeout_base = 12'd2; typ_erase = 12'd2;
      req_addr = 16'h4321;
      pulse(0);
      while (reads_since < 30) @(negedge clk);
      pulse(2);
      while (!suspended) @(negedge clk);
      chk(wd[b+6] == 8'hB0 && wa[b+6] == 16'h4321, "R6 pause write", wd[b+6], 8'hB0);
      chk(suspended && !busy, "R6 held flags", busy, 0);
      w0 = nw; r0 = total_reads;
      repeat (10) @(negedge clk);
      chk(nw == w0 && total_reads == r0, "R11 quiet while held", nw - w0, 0);
      pulse(2); pulse(0); pulse(1);
      repeat (3) @(negedge clk);
      chk(nw == w0 && suspended && err_n == e0, "R9 requests ignored while held", nw - w0, 0);
      pulse(3);
      wait_writes(w0 + 1);
      chk(wd[w0] == 8'h30 && wa[w0] == 16'h4321 && busy && !suspended, "R8 resume write", wd[w0], 8'h30);
      wait_end(done_n, e0);
      chk(wd[w0+1] == 8'hF0 && wr[w0+1] == 40, "R8 timeout restarted", wr[w0+1], 40);
    end

    // R6: pause accepted during the settle window
    begin
      int b, e0;
      b = nw; e0 = err_n;
      erase_reads = 1; susp_reads = 0; typ_erase = 12'd200; timeout_base = 12'd5;
      req_addr = 16'h0A0A;
      pulse(0);
      wait_writes(b + 6);
      repeat (5) @(negedge clk);
      pulse(2);
      while (!suspended) @(negedge clk);
      chk(wd[b+6] == 8'hB0 && wr[b+6] == 0, "R6 pause in settle", wr[b+6], 0);
      pulse(3);
      wait_end(done_n, e0);
      chk(err_n == e0 && wd[b+7] == 8'h30 && !busy, "R6 completes after resume", err_n - e0, 0);
    end

    // R7: pause timeout
    begin
      int b, e0;
      b = nw; e0 = err_n;
      erase_reads = -1; susp_reads = -1; timeout_base = 12'd3; typ_erase = 12'd2;
      req_addr = 16'h5555;
      pulse(0);
      while (reads_since < 6) @(negedge clk);
      pulse(2);
      wait_writes(b + 8);
      chk(wd[b+6] == 8'hB0 && wd[b+7] == 8'h30 && wa[b+7] == 16'h5555, "R7 resume on timeout", wd[b+7], 8'h30);
      chk(wr[b+7] == 4, "R7 pause read count", wr[b+7], 4);
      chk(err_n == e0 + 1 && busy && !suspended, "R7 error and busy", err_n - e0, 1);
      wait_end(done_n, err_n);
      chk(wd[b+8] == 8'hF0 && wr[b+8] == 60, "R7 erase timeout after", wr[b+8], 60);
    end

    // R9: pause/resume ignored when idle; resume ignored while erasing
    begin
      int w0, e0;
      w0 = nw;
      pulse(2); pulse(3);
      repeat (5) @(negedge clk);
      chk(nw == w0 && !busy && !suspended, "R9 idle ignores", nw - w0, 0);
      erase_reads = -1; timeout_base = 12'd1; typ_erase = 12'd2; req_addr = 16'h0100;
      e0 = err_n;
      pulse(0);
      while (reads_since < 4) @(negedge clk);
      pulse(3);
      wait_end(done_n, e0);
      chk(nw == w0 + 7 && wd[w0+6] == 8'hF0 && wr[w0+6] == 20, "R9 resume ignored while erasing", nw - w0, 7);
    end

    // R10: simultaneous requests pick sector
    begin
      int b;
      b = nw;
      erase_reads = 0; timeout_base = 12'd5; req_addr = 16'h0BEE;
      @(negedge clk);
      req_sector_erase = 1; req_chip_erase = 1;
      @(negedge clk);
      req_sector_erase = 0; req_chip_erase = 0;
      wait_end(done_n, err_n);
      chk(seq_ok(b, 16'h0BEE, 8'h30), "R10 sector wins", wd[b+5], 8'h30);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule